// File: doc/BRIEF.md
# Handshaked Shift-Register Command Engine

This block is the peripheral side of a byte-serial command link. A host moves one byte at a time through an 8-bit shift register, which sits outside this block, and paces each byte with two active-low lines held in an 8-bit port. The host drives the request line on bit 3. The device drives the acknowledge line on bit 4. The engine watches every host write to that port and decodes the pair of lines. On each valid byte request it either consumes the byte waiting in the shift register or places a response byte there.

A transaction starts with a command code. Any argument bytes follow it, and then the response bytes flow back. A lookup table gives each code an argument length and a response length. Either length may be "variable". A variable argument length is sent by the host as the first byte after the code. A variable response length is sent by the device as the first response byte. When all the arguments have arrived, the engine pulses a dispatch strobe carrying the code and the argument count. A built-in stub responder then supplies the payload.

Top module: `shreg_cmd_engine`

## Requirements
- R1: After synchronous reset, `port_q` is 0x18 (both lines released), the engine is idle, and `sr_out_valid`, `dispatch` and all three error outputs are 0.
- R2: A port write whose value equals the last evaluated write is not decoded. `port_q` simply takes the written value, and no byte is consumed or produced.
- R3: Only a changed write is decoded. The decoded field is {bit4, bit3}. A value of 11 is idle and does nothing. A value of 00 is a byte request: the device releases bit 4, so `port_q` becomes the written value OR 0x10. A value of 01 is an acknowledge release: `port_q` becomes the written value OR 0x10 and no byte is handled. A value of 10 pulses `err_handshake` and is otherwise ignored.
- R4: In idle, a request takes `sr_in` as the command code and loads both lengths from the table. Table: 0x10 takes 0 args and returns 2 bytes. 0x20 takes 2 args and returns 0 bytes. 0x30 has a variable arg count and a variable response. 0x40 takes 1 arg and has a variable response. 0x50 takes 40 args and returns 1 byte. Codes 0x60–0x6F take 1 arg and return 3 bytes. Codes 0x70–0x7F take 0 args and have a variable response. Every other code takes 0 args and returns 0 bytes. Only 0x10 through 0x50 are known.
- R5: With a variable argument length, the first byte after the code is the argument count.
- R6: Idle and argument bytes need `sr_host_to_dev`=1. Response bytes need `sr_host_to_dev`=0. A request in the wrong direction pulses `err_direction`, drops the byte and leaves the state unchanged.
- R7: When the received argument count reaches the argument length, `dispatch` pulses for one cycle with `dispatch_cmd` and `dispatch_argc`. With a length of 0 this happens on the code byte itself.
- R8: With a variable response length, the first response byte sent is the size, and that size then becomes the response length. For 0x30 the size is min(argc, 32). For 0x40 it is arg0 mod 32. For 0x70–0x7F it is 0.
- R9: The engine returns to idle as soon as the sent count equals the response length, in the same request that reaches it. A zero length completes at once.
- R10: Unknown codes respond with zero bytes of the tabled length. If the tabled response length is variable, they send a size of 0.
- R11: A declared argument length above 32 pulses `err_length` on the request that declares it. Arguments past the 32nd are discarded, but reception still ends at the declared count.
- R12: For known codes, response byte i is argᵢ XOR code XOR i. Arguments that were not received read as 0, because each new code clears the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr_en | input | 1 | Host write strobe for the handshake port |
| port_wr_data | input | 8 | Value written by the host |
| port_q | output | 8 | Current port value, including the device's line |
| sr_in | input | 8 | Byte the host has shifted in |
| sr_host_to_dev | input | 1 | Shift direction, 1 = host to device |
| sr_out | output | 8 | Byte for the shift register to send |
| sr_out_valid | output | 1 | One-cycle pulse: `sr_out` was loaded |
| dispatch | output | 1 | One-cycle pulse: command fully received |
| dispatch_cmd | output | 8 | Code of the dispatched command |
| dispatch_argc | output | 8 | Argument count of the dispatched command |
| err_handshake | output | 1 | Pulse on an invalid line pattern |
| err_direction | output | 1 | Pulse on a request in the wrong shift direction |
| err_length | output | 1 | Pulse on a declared argument length above 32 |

## Verification
Every internal slip becomes visible at the ports one cycle after the port write that caused it. A miscounted argument counter moves the `dispatch` pulse to the wrong byte. A response length that is wrong, or is adopted late, adds or removes `sr_out_valid` pulses, or leaves a later command code to be read as payload. A buffer that is not cleared or not capped shows up as wrong payload values. A state that advanced on a dropped byte shifts every byte that follows.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    localparam int PORT_W    = 8;
    localparam int REQ_BIT   = 3;   // host-driven line, active low
    localparam int ACK_BIT   = 4;   // device-driven line, active low
    localparam int DEPTH_DEF = 32;

    localparam logic [PORT_W-1:0] REQ_MASK = PORT_W'(1) << REQ_BIT;
    localparam logic [PORT_W-1:0] ACK_MASK = PORT_W'(1) << ACK_BIT;
    localparam logic [PORT_W-1:0] PORT_RST = REQ_MASK | ACK_MASK;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_RSP  = 2'd2
    } eng_state_e;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_REQ,
        HS_RELEASE,
        HS_BAD
    } hs_kind_e;

    typedef struct packed {
        logic       cmd_var;
        logic [7:0] cmd_len;
        logic       rsp_var;
        logic [7:0] rsp_len;
    } len_entry_t;

    function automatic hs_kind_e decode_hs(input logic [PORT_W-1:0] v);
        case ({v[ACK_BIT], v[REQ_BIT]})
            2'b11:   return HS_IDLE;
            2'b00:   return HS_REQ;
            2'b01:   return HS_RELEASE;
            default: return HS_BAD;
        endcase
    endfunction

    function automatic len_entry_t lookup_len(input logic [7:0] code);
        len_entry_t e;
        e = '0;
        case (code)
            8'h10: e.rsp_len = 8'd2;
            8'h20: e.cmd_len = 8'd2;
            8'h30: begin e.cmd_var = 1'b1; e.rsp_var = 1'b1; end
            8'h40: begin e.cmd_len = 8'd1; e.rsp_var = 1'b1; end
            8'h50: begin e.cmd_len = 8'd40; e.rsp_len = 8'd1; end
            default: begin
                if (code[7:4] == 4'h6) begin
                    e.cmd_len = 8'd1;
                    e.rsp_len = 8'd3;
                end else if (code[7:4] == 4'h7) begin
                    e.rsp_var = 1'b1;
                end
            end
        endcase
        return e;
    endfunction

    function automatic logic tbl_known(input logic [7:0] code);
        return (code == 8'h10) || (code == 8'h20) || (code == 8'h30) ||
               (code == 8'h40) || (code == 8'h50);
    endfunction

endpackage

// File: rtl/hs_decoder.sv
module hs_decoder
    import shreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] port_q,
    output logic              req_evt,
    output logic              err_handshake
);

    logic [PORT_W-1:0] last_q;
    logic              changed;
    hs_kind_e          kind;

    assign changed = wr_en && (wr_data != last_q);
    assign kind    = decode_hs(wr_data);
    assign req_evt = changed && (kind == HS_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q        <= PORT_RST;
            port_q        <= PORT_RST;
            err_handshake <= 1'b0;
        end else begin
            err_handshake <= changed && (kind == HS_BAD);
            if (wr_en) begin
                if (changed) begin
                    last_q <= wr_data;
                    if (kind == HS_REQ || kind == HS_RELEASE)
                        port_q <= wr_data | ACK_MASK;
                    else
                        port_q <= wr_data;
                end else begin
                    port_q <= wr_data;
                end
            end
        end
    end

    // R3: the device line reads released after every request
    a_r3_ack_on_request: assert property (@(posedge clk) disable iff (rst)
        req_evt |=> port_q[ACK_BIT]);

    // R2: an unchanged write lands unmodified
    a_r2_unchanged_passthrough: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !changed) |=> (port_q == $past(wr_data)));

endmodule

// File: rtl/stub_responder.sv
module stub_responder
    import shreg_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int IDXW  = $clog2(DEPTH)
)(
    input  logic [7:0]      cmd,
    input  logic [7:0]      args [DEPTH],
    input  logic [7:0]      argc,
    input  logic [IDXW-1:0] idx,
    output logic [7:0]      size,
    output logic [7:0]      data
);

    localparam logic [7:0] DEPTH8 = 8'(DEPTH);

    always_comb begin
        case (cmd)
            8'h30:   size = (argc > DEPTH8) ? DEPTH8 : argc;
            8'h40:   size = 8'(args[0][IDXW-1:0]);
            default: size = 8'd0;
        endcase
    end

    assign data = tbl_known(cmd) ? (args[idx] ^ cmd ^ 8'(idx)) : 8'd0;

endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import shreg_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int IDXW  = $clog2(DEPTH)
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_evt,
    input  logic [7:0]      sr_in,
    input  logic            dir_h2d,
    input  logic [7:0]      stub_size,
    input  logic [7:0]      stub_data,
    output logic [7:0]      cmd_q,
    output logic [7:0]      args_q [DEPTH],
    output logic [7:0]      rx_q,
    output logic [IDXW-1:0] tx_idx,
    output logic [7:0]      sr_out,
    output logic            sr_out_valid,
    output logic            dispatch,
    output logic [7:0]      dispatch_cmd,
    output logic [7:0]      dispatch_argc,
    output logic            err_direction,
    output logic            err_length
);

    localparam int         TXW    = IDXW + 1;
    localparam logic [7:0] DEPTH8 = 8'(DEPTH);

    eng_state_e     state_q, n_state;
    logic           cmd_pend_q, n_cmd_pend;
    logic [7:0]     cmd_len_q, n_cmd_len;
    logic           rsp_pend_q, n_rsp_pend;
    logic [7:0]     rsp_len_q, n_rsp_len;
    logic [TXW-1:0] tx_q, n_tx;
    logic [7:0]     n_cmd, n_rx;
    logic [7:0]     n_args [DEPTH];
    logic [7:0]     n_out;
    logic           n_out_vld, n_disp, n_err_dir, n_err_len;
    logic [7:0]     n_disp_cmd, n_disp_argc;
    len_entry_t     ent;

    assign ent    = lookup_len(sr_in);
    assign tx_idx = tx_q[IDXW-1:0];

    always_comb begin
        n_state     = state_q;
        n_cmd       = cmd_q;
        n_cmd_pend  = cmd_pend_q;
        n_cmd_len   = cmd_len_q;
        n_rx        = rx_q;
        n_rsp_pend  = rsp_pend_q;
        n_rsp_len   = rsp_len_q;
        n_tx        = tx_q;
        n_args      = args_q;
        n_out       = sr_out;
        n_out_vld   = 1'b0;
        n_disp      = 1'b0;
        n_disp_cmd  = dispatch_cmd;
        n_disp_argc = dispatch_argc;
        n_err_dir   = 1'b0;
        n_err_len   = 1'b0;
        if (req_evt) begin
            case (state_q)
                ST_IDLE: begin
                    if (!dir_h2d) begin
                        n_err_dir = 1'b1;
                    end else begin
                        n_cmd      = sr_in;
                        n_cmd_pend = ent.cmd_var;
                        n_cmd_len  = ent.cmd_len;
                        n_rsp_pend = ent.rsp_var;
                        n_rsp_len  = ent.rsp_len;
                        n_rx       = '0;
                        n_tx       = '0;
                        for (int i = 0; i < DEPTH; i++) n_args[i] = '0;
                        n_err_len  = !ent.cmd_var && (ent.cmd_len > DEPTH8);
                        n_state    = ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (!dir_h2d) begin
                        n_err_dir = 1'b1;
                    end else if (cmd_pend_q) begin
                        n_cmd_len  = sr_in;
                        n_cmd_pend = 1'b0;
                        n_err_len  = sr_in > DEPTH8;
                    end else begin
                        if (rx_q < DEPTH8) n_args[rx_q[IDXW-1:0]] = sr_in;
                        n_rx = rx_q + 8'd1;
                    end
                end
                ST_RSP: begin
                    if (dir_h2d) begin
                        n_err_dir = 1'b1;
                    end else if (rsp_pend_q) begin
                        n_out      = stub_size;
                        n_out_vld  = 1'b1;
                        n_rsp_len  = stub_size;
                        n_rsp_pend = 1'b0;
                    end else if (8'(tx_q) < rsp_len_q) begin
                        n_out     = stub_data;
                        n_out_vld = 1'b1;
                        n_tx      = tx_q + TXW'(1);
                    end
                end
                default: n_state = ST_IDLE;
            endcase
            // completion checks, both may fire on one request
            if (n_state == ST_CMD && !n_cmd_pend && n_cmd_len == n_rx) begin
                n_disp      = 1'b1;
                n_disp_cmd  = n_cmd;
                n_disp_argc = n_rx;
                n_tx        = '0;
                n_state     = ST_RSP;
            end
            if (n_state == ST_RSP && !n_rsp_pend && n_rsp_len == 8'(n_tx))
                n_state = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            cmd_q         <= '0;
            cmd_pend_q    <= 1'b0;
            cmd_len_q     <= '0;
            rx_q          <= '0;
            rsp_pend_q    <= 1'b0;
            rsp_len_q     <= '0;
            tx_q          <= '0;
            for (int i = 0; i < DEPTH; i++) args_q[i] <= '0;
            sr_out        <= '0;
            sr_out_valid  <= 1'b0;
            dispatch      <= 1'b0;
            dispatch_cmd  <= '0;
            dispatch_argc <= '0;
            err_direction <= 1'b0;
            err_length    <= 1'b0;
        end else begin
            state_q       <= n_state;
            cmd_q         <= n_cmd;
            cmd_pend_q    <= n_cmd_pend;
            cmd_len_q     <= n_cmd_len;
            rx_q          <= n_rx;
            rsp_pend_q    <= n_rsp_pend;
            rsp_len_q     <= n_rsp_len;
            tx_q          <= n_tx;
            args_q        <= n_args;
            sr_out        <= n_out;
            sr_out_valid  <= n_out_vld;
            dispatch      <= n_disp;
            dispatch_cmd  <= n_disp_cmd;
            dispatch_argc <= n_disp_argc;
            err_direction <= n_err_dir;
            err_length    <= n_err_len;
        end
    end

    // R6: a wrong-direction request in idle leaves the engine idle
    a_r6_idle_dir_drop: assert property (@(posedge clk) disable iff (rst)
        (req_evt && state_q == ST_IDLE && !dir_h2d) |=> (state_q == ST_IDLE && err_direction));

    // R4: the code byte is captured from the shift register
    a_r4_code_capture: assert property (@(posedge clk) disable iff (rst)
        (req_evt && state_q == ST_IDLE && dir_h2d) |=> (cmd_q == $past(sr_in)));

    // R7: after a dispatch the engine no longer collects arguments
    a_r7_dispatch_leaves_cmd: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> (state_q != ST_CMD));

    // R9: a known response length is never reached while still responding
    a_r9_tx_bounded: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RSP && !rsp_pend_q) |-> (8'(tx_q) < rsp_len_q));

    // R8: bytes are produced only from the response state
    a_r8_out_from_rsp: assert property (@(posedge clk) disable iff (rst)
        sr_out_valid |-> ($past(state_q) == ST_RSP));

    // R11: length errors arise only while a command is being framed
    a_r11_len_err_source: assert property (@(posedge clk) disable iff (rst)
        err_length |-> ($past(state_q) != ST_RSP));

endmodule

// File: rtl/shreg_cmd_engine.sv
module shreg_cmd_engine
    import shreg_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       port_wr_en,
    input  logic [7:0] port_wr_data,
    output logic [7:0] port_q,
    input  logic [7:0] sr_in,
    input  logic       sr_host_to_dev,
    output logic [7:0] sr_out,
    output logic       sr_out_valid,
    output logic       dispatch,
    output logic [7:0] dispatch_cmd,
    output logic [7:0] dispatch_argc,
    output logic       err_handshake,
    output logic       err_direction,
    output logic       err_length
);

    localparam int IDXW = $clog2(DEPTH);

    logic            req_evt;
    logic [7:0]      cmd_q;
    logic [7:0]      args_q [DEPTH];
    logic [7:0]      rx_q;
    logic [IDXW-1:0] tx_idx;
    logic [7:0]      stub_size;
    logic [7:0]      stub_data;

    hs_decoder u_hs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (port_wr_en),
        .wr_data       (port_wr_data),
        .port_q        (port_q),
        .req_evt       (req_evt),
        .err_handshake (err_handshake)
    );

    frame_fsm #(.DEPTH(DEPTH), .IDXW(IDXW)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_evt       (req_evt),
        .sr_in         (sr_in),
        .dir_h2d       (sr_host_to_dev),
        .stub_size     (stub_size),
        .stub_data     (stub_data),
        .cmd_q         (cmd_q),
        .args_q        (args_q),
        .rx_q          (rx_q),
        .tx_idx        (tx_idx),
        .sr_out        (sr_out),
        .sr_out_valid  (sr_out_valid),
        .dispatch      (dispatch),
        .dispatch_cmd  (dispatch_cmd),
        .dispatch_argc (dispatch_argc),
        .err_direction (err_direction),
        .err_length    (err_length)
    );

    stub_responder #(.DEPTH(DEPTH), .IDXW(IDXW)) u_stub (
        .cmd  (cmd_q),
        .args (args_q),
        .argc (rx_q),
        .idx  (tx_idx),
        .size (stub_size),
        .data (stub_data)
    );

endmodule

// File: tb/tb_shreg_cmd_engine.sv
`timescale 1ns/1ps
module tb_shreg_cmd_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_wr_en = 1'b0;
    logic [7:0] port_wr_data = 8'h18;
    logic [7:0] port_q;
    logic [7:0] sr_in = 8'h00;
    logic       sr_host_to_dev = 1'b1;
    logic [7:0] sr_out;
    logic       sr_out_valid, dispatch, err_handshake, err_direction, err_length;
    logic [7:0] dispatch_cmd, dispatch_argc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shreg_cmd_engine dut (
        .clk(clk), .rst(rst), .port_wr_en(port_wr_en), .port_wr_data(port_wr_data),
        .port_q(port_q), .sr_in(sr_in), .sr_host_to_dev(sr_host_to_dev),
        .sr_out(sr_out), .sr_out_valid(sr_out_valid), .dispatch(dispatch),
        .dispatch_cmd(dispatch_cmd), .dispatch_argc(dispatch_argc),
        .err_handshake(err_handshake), .err_direction(err_direction),
        .err_length(err_length)
    );

    // ---- reference model of the requirements ----
    function automatic bit m_known(input logic [7:0] c);
        return c == 8'h10 || c == 8'h20 || c == 8'h30 || c == 8'h40 || c == 8'h50;
    endfunction
    function automatic bit m_cvar(input logic [7:0] c);
        return c == 8'h30;
    endfunction
    function automatic int m_clen(input logic [7:0] c);
        if (c == 8'h20) return 2;
        if (c == 8'h40) return 1;
        if (c == 8'h50) return 40;
        if (c[7:4] == 4'h6) return 1;
        return 0;
    endfunction
    function automatic bit m_rvar(input logic [7:0] c);
        return c == 8'h30 || c == 8'h40 || c[7:4] == 4'h7;
    endfunction
    function automatic int m_rlen(input logic [7:0] c);
        if (c == 8'h10) return 2;
        if (c == 8'h50) return 1;
        if (c[7:4] == 4'h6) return 3;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wport(input logic [7:0] v);
        @(negedge clk);
        port_wr_en   = 1'b1;
        port_wr_data = v;
        @(negedge clk);
        port_wr_en   = 1'b0;
    endtask

    // one byte request: outputs are sampled by the caller right after
    task automatic xfer(input logic [7:0] b, input bit h2d);
        sr_in          = b;
        sr_host_to_dev = h2d;
        wport(8'h00);
    endtask

    task automatic release_line();
        wport(8'h18);
    endtask

    task automatic run_cmd(input logic [7:0] code, input int var_argc);
        logic [7:0] a [64];
        int n, sz;
        logic [7:0] expb;
        n = m_cvar(code) ? var_argc : m_clen(code);
        for (int i = 0; i < 64; i++) a[i] = (i < n) ? 8'($urandom) : 8'h00;
        xfer(code, 1'b1);
        chk("R11 err_length on code", err_length, 8'(!m_cvar(code) && n > 32));
        if (!m_cvar(code) && n == 0) begin
            chk("R7 dispatch on code", dispatch, 1);
            chk("R7 dispatch_cmd", dispatch_cmd, code);
        end
        release_line();
        if (m_cvar(code)) begin
            xfer(8'(n), 1'b1);
            chk("R5 err_length on count", err_length, 8'(n > 32));
            chk("R5 dispatch on count", dispatch, 8'(n == 0));
            release_line();
        end
        for (int i = 0; i < n; i++) begin
            xfer(a[i], 1'b1);
            chk("R7 dispatch timing", dispatch, 8'(i == n - 1));
            if (i == n - 1) begin
                chk("R7 dispatch_cmd", dispatch_cmd, code);
                chk("R7 dispatch_argc", dispatch_argc, 8'(n));
            end
            release_line();
        end
        if (m_known(code) && code == 8'h30)      sz = (n > 32) ? 32 : n;
        else if (m_known(code) && code == 8'h40) sz = a[0] % 32;
        else if (m_rvar(code))                  sz = 0;
        else                                    sz = m_rlen(code);
        if (m_rvar(code)) begin
            xfer(8'h00, 1'b0);
            chk("R8 size valid", sr_out_valid, 1);
            chk("R8 size byte", sr_out, 8'(sz));
            release_line();
        end
        for (int j = 0; j < sz; j++) begin
            xfer(8'h00, 1'b0);
            expb = m_known(code) ? (a[j] ^ code ^ 8'(j)) : 8'h00;
            chk("R12 R10 byte valid", sr_out_valid, 1);
            chk("R12 R10 payload", sr_out, expb);
            release_line();
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 port_q", port_q, 8'h18);
        chk("R1 sr_out_valid", sr_out_valid, 0);
        chk("R1 dispatch", dispatch, 0);
        chk("R1 err", {5'd0, err_handshake, err_direction, err_length}, 0);

        // R3 acknowledge release pattern
        wport(8'h08);
        chk("R3 release port_q", port_q, 8'h18);
        chk("R3 release no byte", sr_out_valid | dispatch, 0);
        release_line();
        // R3 invalid pattern
        wport(8'h10);
        chk("R3 invalid err", err_handshake, 1);
        chk("R3 invalid port_q", port_q, 8'h10);
        chk("R3 invalid no byte", dispatch, 0);
        release_line();

        // R2 / R3 request, then repeated identical write
        xfer(8'h10, 1'b1);
        chk("R3 req port_q", port_q, 8'h10);
        chk("R4 code 0x10 dispatch", dispatch, 1);
        sr_host_to_dev = 1'b0;
        wport(8'h00);
        chk("R2 no eval valid", sr_out_valid, 0);
        chk("R2 no eval err", err_direction, 0);
        chk("R2 port_q passthrough", port_q, 8'h00);
        release_line();
        xfer(8'h00, 1'b0);
        chk("R12 cleared args b0", sr_out, 8'h10);
        release_line();
        // R6 wrong direction inside the response
        xfer(8'h00, 1'b1);
        chk("R6 rsp dir err", err_direction, 1);
        chk("R6 rsp dir no byte", sr_out_valid, 0);
        release_line();
        xfer(8'h00, 1'b0);
        chk("R12 cleared args b1", sr_out, 8'h11);
        chk("R9 b1 valid", sr_out_valid, 1);
        release_line();

        // R6 wrong direction in idle: byte dropped
        xfer(8'h20, 1'b0);
        chk("R6 idle dir err", err_direction, 1);
        chk("R6 idle no dispatch", dispatch, 0);
        release_line();
        run_cmd(8'h20, 0);

        // R3 stray patterns in the middle of a command
        xfer(8'h20, 1'b1);
        release_line();
        wport(8'h08);
        chk("R3 mid release port_q", port_q, 8'h18);
        wport(8'h10);
        chk("R3 mid invalid err", err_handshake, 1);
        release_line();
        xfer(8'hAA, 1'b1);
        chk("R3 mid no early dispatch", dispatch, 0);
        release_line();
        xfer(8'h55, 1'b1);
        chk("R9 zero rsp dispatch", dispatch, 1);
        chk("R9 zero rsp argc", dispatch_argc, 8'd2);
        release_line();

        // directed framing corners
        run_cmd(8'h30, 0);
        run_cmd(8'h30, 5);
        run_cmd(8'h30, 32);
        run_cmd(8'h30, 35);
        run_cmd(8'h50, 0);
        run_cmd(8'h61, 0);
        run_cmd(8'h72, 0);
        run_cmd(8'h40, 0);
        run_cmd(8'h99, 0);

        // constrained random mix
        for (int k = 0; k < 30; k++) begin
            logic [7:0] codes [8];
            codes = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h6C, 8'h7E, 8'h83};
            run_cmd(codes[$urandom % 8], int'($urandom % 36));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule